// File: doc/BRIEF.md
# Programmable-Rate Serial Peripheral Master

This block is a full-duplex synchronous serial master. On each transfer it shifts one 8-bit word out on `mosi_o` and, at the same time, samples one 8-bit word in from `miso_i`. Both words travel most significant bit first. Software sets up the transfer through a small register port. The control register holds the clock polarity, the clock phase and a chip-select number. The rate register holds a 16-bit half-period count. The transmit register holds the outgoing word.

A one-cycle `start_i` pulse begins a transfer. The block latches the configuration at that moment and pulls the chosen active-low select line low. Sixteen serial clock edges follow, each a fixed number of system cycles apart. The select line then rises. In that same cycle `done_o` pulses, `busy_o` falls and `rx_data_o` holds the received word. The received word can also be read back from the register port.

Top module: `spi_div_master`

## Requirements
- R1: Serial clock edges are spaced exactly BAUD system cycles apart, so one serial clock period is 2×BAUD system cycles.
- R2: A write of 0 or 1 to the rate register (address 1, bits [15:0]) stores 2. Any value from 2 to 65535 is stored unchanged. The stored value reads back at address 1.
- R3: Every transfer has exactly 16 serial clock edges. It sends the 8-bit transmit word on `mosi_o` MSB first and assembles the bits sampled on `miso_i` into `rx_data_o`, MSB first.
- R4: Control bit 0 (polarity) sets the idle level of `sclk_o`. The first edge of a transfer always moves `sclk_o` away from that level.
- R5: Control bit 1 (phase) chooses the edges. With phase 0, data is sampled on odd-numbered edges and changed on even ones. With phase 1, data changes on odd edges and is sampled on even ones. In both cases `mosi_o` shows bit 7 before edge 1.
- R6: Control bits [4:2] hold a select number k. For k in 1 to 7, `cs_n_o[k-1]` is low for the whole transfer and every other line stays high. For k = 0, no line goes low.
- R7: The select line falls in the first busy cycle, BAUD cycles before the first edge. It rises BAUD cycles after the last edge, so a transfer occupies 17×BAUD cycles.
- R8: `busy_o` is high from the cycle after the accepted start until the end of the transfer. `done_o` is high for exactly one cycle, when `busy_o` falls. `rx_data_o` is valid in that cycle, and the word then reads back at address 3.
- R9: A start pulse while busy is ignored. So is a transmit-register write while busy: the running word, its timing and its end are unchanged, and no further transfer begins.
- R10: After reset, `busy_o` and `done_o` are low, every select line is high and `sclk_o` is low. The control register reads 0 and the rate register reads 2.
- R11: When idle, `sclk_o` follows the programmed polarity and every select line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 rate, 2 transmit, 3 receive |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| start_i | input | 1 | Start pulse, accepted only when idle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_data_o | output | 8 | Received word, valid with `done_o` |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 7 | Active-low select lines 1 to 7 (bit 0 is line 1) |

## Verification
The bench runs all four polarity/phase combinations at rates 2, 3, 4 and 7. Each run uses computed transmit and receive words and every select value from 0 to 7.

- The mode sweep shows whether sampling and changing are on the correct edges, since a swapped edge corrupts the words it checks.
- The rate sweep shows whether the edge spacing is set by BAUD and not by a fixed count.
- Words made of all zeros, all ones and single set bits expose bit-order errors and lost end bits.
- Rate writes of 0, 1 and 65535, a long run at rate 300, and a start plus transmit write issued mid-transfer cover the clamp, the wide counter and the ignore rule.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  localparam int WORD_BITS  = 8;
  localparam int RATE_BITS  = 16;
  localparam int SEL_LINES  = 7;
  localparam int RATE_FLOOR = 2;
  localparam int BUS_BITS   = 16;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_RATE = 2'd1,
    RA_TX   = 2'd2,
    RA_RX   = 2'd3
  } reg_addr_e;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/spi_div_regs.sv
module spi_div_regs
  import spi_div_pkg::*;
#(
  parameter int DATA_W   = WORD_BITS,
  parameter int BAUD_W   = RATE_BITS,
  parameter int CTRL_W   = 5,
  parameter int REG_DW   = BUS_BITS,
  parameter int MIN_BAUD = RATE_FLOOR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic [DATA_W-1:0] tx_o
);
  localparam logic [BAUD_W-1:0] FLOOR = BAUD_W'(MIN_BAUD);

  logic [DATA_W-1:0] rx_q;
  logic [BAUD_W-1:0] baud_in;
  logic              baud_low;

  assign baud_in  = wdata_i[BAUD_W-1:0];
  assign baud_low = (baud_in < FLOOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o  <= '0;
      baud_o  <= FLOOR;
      tx_o    <= '0;
      rx_q    <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_i) begin
        case (reg_addr_e'(addr_i))
          RA_CTRL: ctrl_o <= wdata_i[CTRL_W-1:0];
          RA_RATE: baud_o <= baud_low ? FLOOR : baud_in;
          RA_TX:   tx_o   <= wdata_i[DATA_W-1:0];
          default: ;
        endcase
      end
      if (done_i) rx_q <= rx_i;
      case (reg_addr_e'(addr_i))
        RA_CTRL: rdata_o <= REG_DW'(ctrl_o);
        RA_RATE: rdata_o <= REG_DW'(baud_o);
        RA_TX:   rdata_o <= REG_DW'(tx_o);
        default: rdata_o <= REG_DW'(rx_q);
      endcase
    end
  end

  // R2: a too-small rate write lands on the floor value
  a_r2_rate_clamp: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == 2'd1 && baud_low) |=> (baud_o == FLOOR));

  // R2: the stored rate never drops under the floor
  a_r2_rate_floor: assert property (@(posedge clk) disable iff (rst)
    baud_o >= FLOOR);

  // R8: the receive register takes the word presented with done
  a_r8_rx_capture: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (rx_q == $past(rx_i)));
endmodule

// File: rtl/spi_div_tick.sv
module spi_div_tick #(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [BAUD_W-1:0] half_i,
  output logic              tick_o
);
  logic [BAUD_W-1:0] cnt;

  assign tick_o = run_i && (cnt == half_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  // R1: the half-period count restarts after each tick
  a_r1_tick_wrap: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt == '0));

  // R1: while running the count stays below the half period
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt < half_i));
endmodule

// File: rtl/spi_div_engine.sv
module spi_div_engine
  import spi_div_pkg::*;
#(
  parameter int DATA_W   = WORD_BITS,
  parameter int BAUD_W   = RATE_BITS,
  parameter int CS_LINES = SEL_LINES,
  parameter int CSEL_W   = 3,
  parameter int MIN_BAUD = RATE_FLOOR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                cpol_i,
  input  logic                cpha_i,
  input  logic [CSEL_W-1:0]   csel_i,
  input  logic [BAUD_W-1:0]   baud_i,
  input  logic [DATA_W-1:0]   tx_i,
  input  logic                miso_i,
  input  logic                tick_i,
  output logic                run_o,
  output logic [BAUD_W-1:0]   half_o,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic [CS_LINES-1:0] cs_n_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   rx_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int HC_W  = $clog2(EDGES + 1);

  eng_state_e          state;
  logic [HC_W-1:0]     hcnt;
  logic [HC_W-1:0]     edge_idx;
  logic                cpha_q;
  logic [DATA_W-1:0]   tx_sh;
  logic [DATA_W-1:0]   rx_sh;
  logic [CS_LINES-1:0] sel_mask;
  logic                sample_now;
  logic                shift_now;

  for (genvar g = 0; g < CS_LINES; g++) begin : g_sel
    assign sel_mask[g] = (csel_i == CSEL_W'(g + 1));
  end

  assign edge_idx   = hcnt + 1'b1;
  assign sample_now = edge_idx[0] ^ cpha_q;
  assign shift_now  = !sample_now && (edge_idx != HC_W'(1)) &&
                      (edge_idx != HC_W'(EDGES));

  assign run_o  = (state == ENG_RUN);
  assign busy_o = run_o;
  assign mosi_o = tx_sh[DATA_W-1];
  assign rx_o   = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ENG_IDLE;
      hcnt   <= '0;
      cpha_q <= 1'b0;
      half_o <= BAUD_W'(MIN_BAUD);
      tx_sh  <= '0;
      rx_sh  <= '0;
      sclk_o <= 1'b0;
      cs_n_o <= '1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ENG_IDLE: begin
          sclk_o <= cpol_i;
          cs_n_o <= '1;
          if (start_i) begin
            state  <= ENG_RUN;
            hcnt   <= '0;
            cpha_q <= cpha_i;
            half_o <= baud_i;
            tx_sh  <= tx_i;
            rx_sh  <= '0;
            cs_n_o <= ~sel_mask;
          end
        end
        default: begin
          if (tick_i) begin
            if (hcnt == HC_W'(EDGES)) begin
              state  <= ENG_IDLE;
              cs_n_o <= '1;
              done_o <= 1'b1;
            end else begin
              sclk_o <= ~sclk_o;
              hcnt   <= edge_idx;
              if (sample_now) rx_sh <= {rx_sh[DATA_W-2:0], miso_i};
              if (shift_now)  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
          end
        end
      endcase
    end
  end

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: done marks the cycle busy has just dropped
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R6: never more than one select line low
  a_r6_one_select: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> $onehot0(~cs_n_o));

  // R11: all select lines high when idle
  a_r11_idle_select: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (&cs_n_o));

  // R11: idle clock follows a steady polarity setting
  a_r11_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o) && $stable(cpol_i)) |-> (sclk_o == cpol_i));

  // R1: the serial clock moves only on a half-period tick
  a_r1_clock_on_tick: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick_i) |=> $stable(sclk_o));

  // R9: a start while busy leaves the latched setup alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(half_o) && $stable(cpha_q)));
endmodule

// File: rtl/spi_div_master.sv
module spi_div_master
  import spi_div_pkg::*;
#(
  parameter int DATA_W   = WORD_BITS,
  parameter int BAUD_W   = RATE_BITS,
  parameter int CS_LINES = SEL_LINES,
  parameter int REG_DW   = BUS_BITS,
  parameter int MIN_BAUD = RATE_FLOOR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  input  logic                start_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   rx_data_o,
  output logic                sclk_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic [CS_LINES-1:0] cs_n_o
);
  localparam int CSEL_W = $clog2(CS_LINES + 1);
  localparam int CTRL_W = CSEL_W + 2;

  logic [CTRL_W-1:0] ctrl;
  logic [BAUD_W-1:0] baud;
  logic [DATA_W-1:0] tx_word;
  logic              run;
  logic              tick;
  logic [BAUD_W-1:0] half;

  spi_div_regs #(
    .DATA_W(DATA_W), .BAUD_W(BAUD_W), .CTRL_W(CTRL_W),
    .REG_DW(REG_DW), .MIN_BAUD(MIN_BAUD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .done_i(done_o),
    .rx_i(rx_data_o), .ctrl_o(ctrl), .baud_o(baud), .tx_o(tx_word)
  );

  spi_div_tick #(.BAUD_W(BAUD_W)) u_tick (
    .clk(clk), .rst(rst), .run_i(run), .half_i(half), .tick_o(tick)
  );

  spi_div_engine #(
    .DATA_W(DATA_W), .BAUD_W(BAUD_W), .CS_LINES(CS_LINES),
    .CSEL_W(CSEL_W), .MIN_BAUD(MIN_BAUD)
  ) u_eng (
    .clk(clk), .rst(rst), .start_i(start_i),
    .cpol_i(ctrl[0]), .cpha_i(ctrl[1]), .csel_i(ctrl[CTRL_W-1:2]),
    .baud_i(baud), .tx_i(tx_word), .miso_i(miso_i), .tick_i(tick),
    .run_o(run), .half_o(half), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .cs_n_o(cs_n_o), .busy_o(busy_o), .done_o(done_o), .rx_o(rx_data_o)
  );
endmodule

// File: tb/tb_spi_div_master.sv
module tb_spi_div_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        start_i = 1'b0;
  logic        busy_o, done_o, sclk_o, mosi_o;
  logic        miso_i = 1'b0;
  logic [7:0]  rx_data_o;
  logic [6:0]  cs_n_o;

  always #5 clk = ~clk;

  spi_div_master dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .rx_data_o(rx_data_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // slave model and timing monitor state
  int         exp_baud = 2;
  logic       exp_cpol = 1'b0, exp_cpha = 1'b0;
  logic [6:0] exp_mask = 7'd0;
  logic [7:0] pat = 8'd0;
  logic [7:0] mon_mosi = 8'd0;
  int t0 = 0, ecnt = 0, tim_err = 0, cs_err = 0, lvl_err = 0;
  logic p_sclk = 1'b0, p_busy = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (busy_o && !p_busy) begin
      t0 = cyc; ecnt = 0; mon_mosi = 8'd0;
      miso_i = pat[7];
      if (sclk_o !== exp_cpol) lvl_err++;
    end else if (busy_o && sclk_o !== p_sclk) begin
      ecnt++;
      if (cyc != t0 + ecnt * exp_baud) tim_err++;
      if (ecnt == 1 && sclk_o !== ~exp_cpol) lvl_err++;
      if (((ecnt % 2) == 1) != exp_cpha)
        mon_mosi = {mon_mosi[6:0], mosi_o};
      else if (ecnt != 1 && ecnt != 16)
        miso_i = pat[7 - (exp_cpha ? (ecnt - 1) / 2 : ecnt / 2)];
    end
    if (!busy_o && p_busy && cyc != t0 + 17 * exp_baud) tim_err++;
    if (busy_o && cs_n_o !== ~exp_mask) cs_err++;
    p_sclk = sclk_o;
    p_busy = busy_o;
  end

  task automatic write_reg(input int a, input int d);
    reg_wr = 1'b1; reg_addr = a[1:0]; reg_wdata = d[15:0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input int a, output int v);
    reg_addr = a[1:0];
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic do_xfer(input int cpol, input int cpha, input int cs,
                         input int baudw, input int tx, input int px,
                         input bit poke);
    int eb, n, v;
    eb = (baudw < 2) ? 2 : baudw;
    write_reg((cs << 2) | (cpha << 1) | cpol, 0);
    write_reg(0, (cs << 2) | (cpha << 1) | cpol);
    write_reg(1, baudw);
    write_reg(2, tx);
    @(negedge clk);
    @(negedge clk);
    chk(sclk_o == cpol[0], "R11", "idle sclk", sclk_o, cpol);
    chk(cs_n_o == 7'h7f, "R11", "idle selects", cs_n_o, 7'h7f);
    exp_cpol = cpol[0]; exp_cpha = cpha[0]; exp_baud = eb; pat = px[7:0];
    exp_mask = (cs == 0) ? 7'd0 : 7'(1 << (cs - 1));
    tim_err = 0; cs_err = 0; lvl_err = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
    n = 0;
    while (!done_o && n < 40 * eb + 100) begin
      @(negedge clk);
      n++;
      if (poke && n == 3 * eb) begin
        start_i = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2;
        reg_wdata = 16'(~tx & 8'hff);
        @(negedge clk);
        n++;
        start_i = 1'b0; reg_wr = 1'b0;
      end
    end
    chk(done_o == 1'b1, "R8", "done seen", done_o, 1);
    #1;
    chk(rx_data_o == px[7:0], "R3", "received word", rx_data_o, px);
    chk(mon_mosi == tx[7:0], poke ? "R9" : "R3", "sent word", mon_mosi, tx);
    chk(ecnt == 16, "R3", "edge count", ecnt, 16);
    chk(tim_err == 0, "R1 R7", "edge timing errors", tim_err, 0);
    chk(cs_err == 0, "R6", "select errors", cs_err, 0);
    chk(lvl_err == 0, cpha ? "R4 R5" : "R4", "polarity errors", lvl_err, 0);
    chk(busy_o == 1'b0, "R8", "busy at done", busy_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8", "done width", done_o, 0);
    if (poke) begin
      repeat (3 * eb + 4) @(negedge clk);
      chk(busy_o == 1'b0 && cs_n_o == 7'h7f, "R9", "no second transfer",
          {busy_o, cs_n_o}, 8'h7f);
      read_reg(2, v);
      chk(v == (~tx & 8'hff), "R9", "tx write while busy stored", v, ~tx & 8'hff);
    end
    read_reg(3, v);
    chk(v == px, "R8", "receive readback", v, px);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy_o == 1'b0, "R10", "busy reset", busy_o, 0);
    chk(done_o == 1'b0, "R10", "done reset", done_o, 0);
    chk(cs_n_o == 7'h7f, "R10", "selects reset", cs_n_o, 7'h7f);
    chk(sclk_o == 1'b0, "R10", "sclk reset", sclk_o, 0);
    read_reg(0, v); chk(v == 0, "R10", "ctrl reset", v, 0);
    read_reg(1, v); chk(v == 2, "R10", "rate reset", v, 2);

    // R2 clamp and pass-through
    write_reg(1, 0);     read_reg(1, v); chk(v == 2, "R2", "rate 0 clamp", v, 2);
    write_reg(1, 1);     read_reg(1, v); chk(v == 2, "R2", "rate 1 clamp", v, 2);
    write_reg(1, 3);     read_reg(1, v); chk(v == 3, "R2", "rate 3 kept", v, 3);
    write_reg(1, 65535); read_reg(1, v); chk(v == 65535, "R2", "rate max kept", v, 65535);

    // R11 idle level follows polarity
    write_reg(0, 1); @(negedge clk);
    chk(sclk_o == 1'b1, "R11", "idle high", sclk_o, 1);
    write_reg(0, 0); @(negedge clk);
    chk(sclk_o == 1'b0, "R11", "idle low", sclk_o, 0);

    // R2 clamped rates give 2-cycle edge spacing
    do_xfer(0, 0, 1, 0, 8'hA5, 8'h5A, 1'b0);
    do_xfer(1, 1, 7, 1, 8'h3C, 8'hC3, 1'b0);

    // R3 corner words
    do_xfer(0, 0, 2, 2, 8'h00, 8'hFF, 1'b0);
    do_xfer(0, 1, 3, 3, 8'hFF, 8'h00, 1'b0);
    do_xfer(1, 0, 4, 2, 8'h80, 8'h01, 1'b0);
    do_xfer(1, 1, 5, 4, 8'h01, 8'h80, 1'b0);

    // R4 R5 R6 sweep over modes, rates and selects
    for (int m = 0; m < 4; m++) begin
      for (int bi = 0; bi < 4; bi++) begin
        for (int k = 0; k < 3; k++) begin
          int idx, b;
          idx = m * 12 + bi * 3 + k;
          b = (bi == 0) ? 2 : (bi == 1) ? 3 : (bi == 2) ? 4 : 7;
          do_xfer(m % 2, m / 2, idx % 8, b, (idx * 37 + 5) & 255,
                  ((idx * 91 + 200) ^ (idx << 3)) & 255, 1'b0);
        end
      end
    end

    // R1 wide rate
    do_xfer(1, 0, 6, 300, 8'h96, 8'h69, 1'b0);

    // R9 start and transmit write while busy
    do_xfer(0, 1, 3, 5, 8'hD2, 8'h4B, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule